// File: doc/BRIEF.md
# SEC-DED Block Encoder Engine

This block is a memory-to-memory engine. It converts a batch of 11-bit message blocks into 16-bit codewords that can correct any single-bit error and detect any double-bit error. It works on a byte-wide, single-port synchronous RAM that it shares with a host. Each message is stored as two bytes. The engine reads both bytes, forms four Hamming check bits and one overall parity bit, and interleaves them with the data bits. It then writes the two codeword bytes into an output region at the matching offset.

The host controls the engine with a start/done handshake. While `start` is high, the host owns the memory and loads operands. The engine stays idle and never writes. When `start` falls, the engine processes every block in sequence. It raises `done` once the final byte is stored, and holds it until the host raises `start` again. If `start` rises during a run, the run is abandoned. The next falling edge of `start` restarts the batch from the first block.

Top module: `secded_enc_engine`

## Requirements
- R1: Message k is read from two bytes. The byte at IN_BASE+2k holds b8..b1 in bits 7..0. The byte at IN_BASE+2k+1 holds b11..b9 in bits 2..0. Bits 7..3 of that upper byte are ignored and have no effect on the codeword.
- R2: The codeword for message k is written with its lower byte at OUT_BASE+2k and its upper byte at OUT_BASE+2k+1. The defaults are 15 blocks, IN_BASE=0 and OUT_BASE=30.
- R3: The upper codeword byte is {b11,b10,b9,b8,b7,b6,b5,p8}, written from bit 7 down to bit 0, where p8 is the XOR of b5 through b11.
- R4: The lower codeword byte is {b4,b3,b2,p4,b1,p2,p1,p16}, written from bit 7 down to bit 0, where:
  - p4 is the XOR of b2, b3, b4, b8, b9, b10 and b11;
  - p2 is the XOR of b1, b3, b4, b6, b7, b10 and b11;
  - p1 is the XOR of b1, b2, b4, b5, b7, b9 and b11.
- R5: p16 makes the whole 16-bit codeword even parity. The message 0x555 therefore encodes to upper byte 0xAA and lower byte 0x5A.
- R6: No write is issued while `start` is high. If `start` rises during a run, no further writes occur, `done` stays low, and the next fall of `start` restarts at block 0.
- R7: A run begins at the first rising edge where `start` is low after having been high. `done` is first seen high 5*NUM_BLOCKS+1 clocks later (76 with the defaults), after the last byte is stored.
- R8: `done` stays high while `start` stays low. It is low from the first rising edge at which `start` is seen high.
- R9: After a synchronous active-high reset, `done` is low, no write occurs, and holding `start` low does not begin a run.
- R10: The engine writes no address outside OUT_BASE..OUT_BASE+2*NUM_BLOCKS-1. The input region and all other memory bytes are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | High: host owns memory; falling edge starts a run |
| done | output | 1 | High once all codewords are stored |
| mem_addr | output | ADDR_W | Memory address for read or write |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | 8 | Byte to write |
| mem_rdata | input | 8 | Read data, one cycle after the address |

## Verification
The hardest situation to reach from the ports is `start` rising in the middle of a batch. At that moment some codewords are stored and others are not, and a write may be scheduled for that very cycle. The bench handles this in three steps. It pre-fills the output region with a marker and releases `start`. It then raises `start` again after a fixed number of cycles, which lands inside the fifth block. Finally, it confirms three things: the engine made no write while `start` was high, the later blocks still hold the marker, and a fresh fall of `start` rebuilds the whole batch from block 0. Nonzero pad bits and walking single-bit messages exercise each parity equation on its own.

// File: rtl/secded_pkg.sv
package secded_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_WAIT_HI,
        ST_WR_LO,
        ST_WR_HI,
        ST_DONE
    } eng_state_t;

    typedef enum logic [1:0] {
        SEL_IN_LO,
        SEL_IN_HI,
        SEL_OUT_LO,
        SEL_OUT_HI
    } addr_sel_t;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } codeword_t;

    localparam int MSG_W    = 11;
    localparam int N_CHECKS = 4;

    // Coverage masks over message bits m[10:0] (m[i] is b(i+1)); index 3 -> p8, 2 -> p4, 1 -> p2, 0 -> p1
    localparam logic [MSG_W-1:0] CHECK_MASK [N_CHECKS] = '{
        11'b10101011011,
        11'b11001101101,
        11'b11110001110,
        11'b11111110000
    };

    function automatic codeword_t pack_code(input logic [MSG_W-1:0] m,
                                            input logic [N_CHECKS-1:0] chk,
                                            input logic overall);
        codeword_t c;
        c.hi = {m[10:4], chk[3]};
        c.lo = {m[3:1], chk[2], m[0], chk[1], chk[0], overall};
        return c;
    endfunction

endpackage

// File: rtl/secded_parity_unit.sv
module secded_parity_unit
    import secded_pkg::*;
(
    input  logic [MSG_W-1:0] msg,
    output codeword_t        code
);
    logic [N_CHECKS-1:0] chk;
    logic                overall;

    generate
        for (genvar g = 0; g < N_CHECKS; g++) begin : g_check
            assign chk[g] = ^(msg & CHECK_MASK[g]);
        end
    endgenerate

    assign overall = (^msg) ^ (^chk);
    assign code    = pack_code(msg, chk, overall);

endmodule

// File: rtl/secded_addr_gen.sv
module secded_addr_gen
    import secded_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_BLOCKS = 15,
    parameter int IN_BASE    = 0,
    parameter int OUT_BASE   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_clr,
    input  logic              cnt_inc,
    input  addr_sel_t         sel,
    output logic [ADDR_W-1:0] addr,
    output logic              last_blk
);
    localparam int CNT_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_BLOCKS - 1);

    logic [CNT_W-1:0]  blk;
    logic [ADDR_W-1:0] pair_off;
    logic [ADDR_W-1:0] base;
    logic              upper;

    always_ff @(posedge clk) begin
        if (rst || cnt_clr) begin
            blk <= '0;
        end else if (cnt_inc && blk != LAST) begin
            blk <= blk + 1'b1;
        end
    end

    always_comb begin
        base  = ADDR_W'(IN_BASE);
        upper = 1'b0;
        case (sel)
            SEL_IN_LO:  begin base = ADDR_W'(IN_BASE);  upper = 1'b0; end
            SEL_IN_HI:  begin base = ADDR_W'(IN_BASE);  upper = 1'b1; end
            SEL_OUT_LO: begin base = ADDR_W'(OUT_BASE); upper = 1'b0; end
            SEL_OUT_HI: begin base = ADDR_W'(OUT_BASE); upper = 1'b1; end
            default:    begin base = ADDR_W'(IN_BASE);  upper = 1'b0; end
        endcase
    end

    assign pair_off = ADDR_W'({blk, 1'b0});
    assign addr     = base + pair_off + ADDR_W'(upper);
    assign last_blk = (blk == LAST);

    // R2: block index never passes the final block
    assert_blk_in_range_R2: assert property (@(posedge clk) disable iff (rst)
        blk <= LAST);

endmodule

// File: rtl/secded_ctrl.sv
module secded_ctrl
    import secded_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      start,
    input  logic      last_blk,
    output addr_sel_t sel,
    output logic      we,
    output logic      cap_lo,
    output logic      cap_hi,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output logic      done
);
    eng_state_t state, state_nx;
    logic       start_q;
    logic       start_fall;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            start_q <= 1'b0;
        end else begin
            state   <= state_nx;
            start_q <= start;
        end
    end

    assign start_fall = start_q && !start;

    always_comb begin
        state_nx = state;
        sel      = SEL_IN_LO;
        we       = 1'b0;
        cap_lo   = 1'b0;
        cap_hi   = 1'b0;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (start_fall) begin
                    state_nx = ST_RD_LO;
                    cnt_clr  = 1'b1;
                end
            end
            ST_RD_LO: begin
                sel      = SEL_IN_LO;
                state_nx = start ? ST_IDLE : ST_RD_HI;
            end
            ST_RD_HI: begin
                sel      = SEL_IN_HI;
                cap_lo   = 1'b1;
                state_nx = start ? ST_IDLE : ST_WAIT_HI;
            end
            ST_WAIT_HI: begin
                sel      = SEL_IN_HI;
                cap_hi   = 1'b1;
                state_nx = start ? ST_IDLE : ST_WR_LO;
            end
            ST_WR_LO: begin
                sel      = SEL_OUT_LO;
                we       = !start;
                state_nx = start ? ST_IDLE : ST_WR_HI;
            end
            ST_WR_HI: begin
                sel      = SEL_OUT_HI;
                we       = !start;
                if (start) begin
                    state_nx = ST_IDLE;
                end else if (last_blk) begin
                    state_nx = ST_DONE;
                end else begin
                    state_nx = ST_RD_LO;
                    cnt_inc  = 1'b1;
                end
            end
            ST_DONE: begin
                if (start) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    assign done = (state == ST_DONE);

    // R8: done drops on the edge after start is seen high
    assert_done_drops_R8: assert property (@(posedge clk) disable iff (rst)
        (done && start) |=> !done);

    // R7: an idle engine seeing start fall moves into the read sequence
    assert_run_begins_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE && start_fall) |=> (state == ST_RD_LO));

    // R6: start high during a run returns the engine to idle
    assert_abort_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (state != ST_IDLE && state != ST_DONE && start) |=> (state == ST_IDLE));

endmodule

// File: rtl/secded_enc_engine.sv
module secded_enc_engine
    import secded_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NUM_BLOCKS = 15,
    parameter int IN_BASE    = 0,
    parameter int OUT_BASE   = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int OUT_LAST = OUT_BASE + 2 * NUM_BLOCKS - 1;

    addr_sel_t  sel;
    logic       cap_lo, cap_hi, cnt_clr, cnt_inc, last_blk;
    logic [7:0] data_lo;
    logic [2:0] data_hi;
    logic       unused_pad;
    codeword_t  code;

    secded_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .last_blk (last_blk),
        .sel      (sel),
        .we       (mem_we),
        .cap_lo   (cap_lo),
        .cap_hi   (cap_hi),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .done     (done)
    );

    secded_addr_gen #(
        .ADDR_W     (ADDR_W),
        .NUM_BLOCKS (NUM_BLOCKS),
        .IN_BASE    (IN_BASE),
        .OUT_BASE   (OUT_BASE)
    ) u_addr (
        .clk      (clk),
        .rst      (rst),
        .cnt_clr  (cnt_clr),
        .cnt_inc  (cnt_inc),
        .sel      (sel),
        .addr     (mem_addr),
        .last_blk (last_blk)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            data_lo <= '0;
            data_hi <= '0;
        end else begin
            if (cap_lo) data_lo <= mem_rdata;
            if (cap_hi) data_hi <= mem_rdata[2:0];
        end
    end

    assign unused_pad = ^mem_rdata[7:3];

    secded_parity_unit u_parity (
        .msg  ({data_hi, data_lo}),
        .code (code)
    );

    assign mem_wdata = (sel == SEL_OUT_HI) ? code.hi : code.lo;

    // R6: no write while the host owns memory
    assert_no_write_in_start_R6: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> !start);

    // R10: writes land only in the output region
    assert_write_range_R10: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (int'(mem_addr) >= OUT_BASE && int'(mem_addr) <= OUT_LAST));

    // R5: a stored codeword has even parity over both bytes
    assert_even_parity_R5: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> (^{code.hi, code.lo}) == 1'b0);

    // R7: done only rises right after a write
    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(mem_we));

    // R9: done and write never coincide
    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !mem_we);

endmodule

// File: tb/secded_enc_engine_bench.sv
module secded_enc_engine_bench;
    localparam int NB    = 15;
    localparam int OBASE = 30;
    localparam logic [7:0] SENT = 8'hC3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       done;
    logic [7:0] mem_addr;
    logic       mem_we;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata;

    logic       tb_we = 1'b0;
    logic [7:0] tb_addr = '0;
    logic [7:0] tb_wd = '0;

    logic [7:0] mem [256];
    logic [7:0] in_img [2*NB];

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    int bad_wr  = 0;
    int oob_wr  = 0;

    always #10 clk = ~clk;

    secded_enc_engine u_secded_enc_engine (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .done      (done),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata)
    );

    always_ff @(posedge clk) begin
        if (start) begin
            if (tb_we) mem[tb_addr] <= tb_wd;
            mem_rdata <= mem[tb_addr];
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mem_we && start) bad_wr <= bad_wr + 1;
        if (mem_we && (mem_addr < 8'(OBASE) || mem_addr > 8'(OBASE + 2*NB - 1)))
            oob_wr <= oob_wr + 1;
        if (cyc > 150000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cyc);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    function automatic logic [15:0] ref_code(input logic [10:0] m);
        logic p8, p4, p2, p1, p16;
        p8  = m[10] ^ m[9] ^ m[8] ^ m[7] ^ m[6] ^ m[5] ^ m[4];
        p4  = m[10] ^ m[9] ^ m[8] ^ m[7] ^ m[3] ^ m[2] ^ m[1];
        p2  = m[10] ^ m[9] ^ m[6] ^ m[5] ^ m[3] ^ m[2] ^ m[0];
        p1  = m[10] ^ m[8] ^ m[6] ^ m[4] ^ m[3] ^ m[1] ^ m[0];
        p16 = (^m) ^ p8 ^ p4 ^ p2 ^ p1;
        return {m[10:4], p8, m[3], m[2], m[1], p4, m[0], p2, p1, p16};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        tb_we = 1'b1; tb_addr = 8'(a); tb_wd = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    // Raise start, load messages (pad field set to pad), release start; return cycles to done
    task automatic run_job(input logic [10:0] msgs [NB], input logic [4:0] pad, output int lat);
        start = 1'b1;
        @(negedge clk);
        for (int k = 0; k < NB; k++) begin
            in_img[2*k]   = msgs[k][7:0];
            in_img[2*k+1] = {pad, msgs[k][10:8]};
            host_write(2*k, in_img[2*k]);
            host_write(2*k+1, in_img[2*k+1]);
        end
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic check_outputs(input logic [10:0] msgs [NB], input string req);
        int errs;
        errs = 0;
        for (int k = 0; k < NB; k++) begin
            logic [15:0] e;
            e = ref_code(msgs[k]);
            check({req, " lower byte"}, 32'(mem[OBASE+2*k]), 32'(e[7:0]));
            check({req, " upper byte"}, 32'(mem[OBASE+2*k+1]), 32'(e[15:8]));
        end
        for (int a = 0; a < 2*NB; a++) if (mem[a] !== in_img[a]) errs++;
        for (int a = OBASE + 2*NB; a < 256; a++) if (mem[a] !== SENT) errs++;
        check("R10 bytes outside output region unchanged", 32'(errs), 32'd0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (12) @(negedge clk);
        check("R9 done low after reset with start low", 32'(done), 32'd0);
        check("R9 no write after reset", 32'(oob_wr + bad_wr), 32'd0);
        start = 1'b1;
        @(negedge clk);
        for (int a = 0; a < 256; a++) host_write(a, SENT);
    endtask

    task automatic t_example;
        logic [10:0] m [NB];
        int lat;
        for (int k = 0; k < NB; k++) m[k] = 11'h555;
        run_job(m, 5'b0, lat);
        check("R7 done latency", 32'(lat), 32'd76);
        check("R5 example upper byte 0xAA", 32'(mem[OBASE+1]), 32'hAA);
        check("R5 example lower byte 0x5A", 32'(mem[OBASE]), 32'h5A);
        check_outputs(m, "R2 example batch");
    endtask

    task automatic t_handshake;
        repeat (30) @(negedge clk);
        check("R8 done held while start low", 32'(done), 32'd1);
        start = 1'b1;
        @(negedge clk);
        check("R8 done low one clock after start rises", 32'(done), 32'd0);
        start = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_corners;
        logic [10:0] m [NB];
        int lat;
        for (int k = 0; k < NB; k++) m[k] = (k % 2 == 0) ? 11'h000 : 11'h7FF;
        run_job(m, 5'b11111, lat);
        check("R1 pad bits ignored, done latency", 32'(lat), 32'd76);
        check_outputs(m, "R1 R3 zeros/ones with pad set");
    endtask

    task automatic t_walking;
        logic [10:0] m [NB];
        int lat;
        for (int k = 0; k < NB; k++) m[k] = (k < 11) ? (11'd1 << k) : 11'(k * 73);
        run_job(m, 5'b10101, lat);
        check_outputs(m, "R4 walking single bits");
    endtask

    task automatic t_pattern;
        logic [10:0] m [NB];
        logic [10:0] s;
        int lat;
        s = 11'h2B7;
        for (int k = 0; k < NB; k++) begin
            m[k] = s;
            s = {s[9:0], s[10] ^ s[8]};
        end
        run_job(m, 5'b01110, lat);
        check_outputs(m, "R5 pseudo-random messages");
    endtask

    task automatic t_abort;
        logic [10:0] m [NB];
        int lat, untouched;
        for (int k = 0; k < NB; k++) m[k] = 11'(k * 137 + 5);
        start = 1'b1;
        @(negedge clk);
        for (int a = OBASE; a < OBASE + 2*NB; a++) host_write(a, 8'h3C);
        for (int k = 0; k < NB; k++) begin
            in_img[2*k]   = m[k][7:0];
            in_img[2*k+1] = {5'b0, m[k][10:8]};
            host_write(2*k, in_img[2*k]);
            host_write(2*k+1, in_img[2*k+1]);
        end
        start = 1'b0;
        repeat (23) @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (done) n_fail++;
        end
        n_tests++;
        check("R6 no write while start high", 32'(bad_wr), 32'd0);
        untouched = 0;
        for (int a = OBASE + 10; a < OBASE + 2*NB; a++) if (mem[a] === 8'h3C) untouched++;
        check("R6 later blocks untouched after abort", 32'(untouched), 32'(2*NB - 10));
        start = 1'b0;
        lat = 0;
        while (!done && lat < 500) begin
            @(negedge clk);
            lat++;
        end
        check("R6 restart from block 0 latency", 32'(lat), 32'd76);
        check_outputs(m, "R6 restart batch");
        start = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        t_reset;
        t_example;
        t_handshake;
        t_corners;
        t_walking;
        t_pattern;
        t_abort;
        check("R10 no out-of-region writes", 32'(oob_wr), 32'd0);
        check("R6 no writes with start high overall", 32'(bad_wr), 32'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule